// File: doc/BRIEF.md
# LCD Common Electrode Scan Sequencer

This block decides which of 184 common electrodes of a passive-matrix panel is driven during each line period, and which RAM line feeds it. Each `line_tick` closes one line period. The block then presents the next electrode index together with the matching RAM line address. A `frame_start` pulse captures a new configuration and restarts the sequence. A one-cycle `frame_done` pulse marks the line period that follows the last active line.

The visiting order comes from a 3-bit scan code, which selects one of six orders:

| Code | Order | First electrode |
|------|-------|-----------------|
| 0 | plain ascending | 0 |
| 1 | plain descending | 183 |
| 2 | lower-first interlace | 0 |
| 3 | lower-first interlace, reversed | 183 |
| 4 | upper-first interlace | 92 |
| 5 | upper-first interlace, reversed | 91 |

An interlaced order takes groups of four electrodes in turn from the lower half (0 to 91) and the upper half (92 to 183).

A display window selects a consecutive stretch of that order. The window opens at a block of four positions and runs for a programmed number of lines. The RAM line address starts at four times the start-line setting and steps with every emitted line, modulo 368.

The controller is built around four named states:

| State | Meaning |
|-------|---------|
| ST_IDLE | After reset, before any frame |
| ST_ARMED | Configuration captured, no line emitted yet |
| ST_SCAN | Lines are being emitted |
| ST_DONE | All window lines emitted |

The transitions are:

| Transition | Trigger |
|------------|---------|
| any state → ST_ARMED | `frame_start` |
| ST_ARMED or ST_SCAN → ST_SCAN | `line_tick` while window lines remain |
| ST_ARMED or ST_SCAN → ST_DONE | `line_tick` with no lines left; this also pulses `frame_done` |

ST_IDLE and ST_DONE hold until the next `frame_start`.

Top module: `lcd_com_sequencer`

## Requirements
- R1: After reset, `com_idx` is 0, `line_addr` is 0, `com_valid` is 0 and `frame_done` is 0. Ticks given before the first frame start change none of them.
- R2: Scan code 0 visits position p as electrode p. Code 1 visits it as electrode 183−p.
- R3: Code 2 maps position p as follows. Let h = p/8 and w = p mod 8. If w < 4, the electrode is 4h+w; otherwise it is 92+4h+(w−4). Code 3 gives 183 minus the code-2 electrode.
- R4: Code 4 swaps the two halves of code 2, so it starts at electrode 92. Code 5 gives 183 minus the code-4 electrode, so it starts at electrode 91.
- R5: Scan codes 6 and 7 behave exactly like code 0.
- R6: The window block value b (0 to 45) makes the first emitted position 4b. A value above 45 is taken as 0. The number of emitted lines equals the line count, limited to 184−4b.
- R7: The first emitted line has `line_addr` equal to 4 × start line. Each following line adds 1, wrapping from 367 to 0. A start line above 91 is taken as 0.
- R8: On the tick after the last window line, `frame_done` is high for exactly one cycle and `com_valid` drops to 0. With a line count of 0, this happens on the first tick.
- R9: Outputs change only on a tick that is processed. Ticks in the done state leave all outputs unchanged, apart from the done pulse ending.
- R10: Configuration inputs are used only in the cycle `frame_start` is high. A tick in that same cycle is ignored. `com_valid` is 0 until the first tick after the start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_tick | input | 1 | One-cycle pulse ending a line period |
| frame_start | input | 1 | One-cycle pulse capturing configuration and restarting |
| cfg_scan | input | 3 | Scan order code |
| cfg_start | input | 7 | Display start line (address = 4 × value) |
| cfg_lines | input | 8 | Number of active lines |
| cfg_block | input | 6 | Window start in blocks of four positions |
| com_idx | output | 8 | Electrode driven in the current line period |
| com_valid | output | 1 | `com_idx` and `line_addr` describe an active line |
| line_addr | output | 9 | RAM line feeding the current electrode |
| frame_done | output | 1 | One-cycle pulse after the last active line |

## Verification
A wrong position counter or scan code shows at the ports on the very next tick, as an electrode index that differs from the mapped order. The interlace orders expose a bad group or half decision within eight lines. A wrong address counter shows as a `line_addr` that breaks the start-line relation on the first emitted line, or fails to wrap at 367. A wrong remaining-line count surfaces at the end of the window: `frame_done` arrives one tick early or late, or `com_valid` stays high past the window.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    localparam int COM_N   = 184;
    localparam int GRP     = 4;
    localparam int LINE_N  = 2 * COM_N;
    localparam int HALF    = COM_N / 2;
    localparam int BLK_N   = COM_N / GRP;
    localparam int START_N = LINE_N / GRP;
    localparam int COM_W   = $clog2(COM_N + 1);
    localparam int ADDR_W  = $clog2(LINE_N);
    localparam int START_W = $clog2(START_N);
    localparam int BLK_W   = $clog2(BLK_N);
    localparam int SCAN_W  = 3;

    typedef enum logic [SCAN_W-1:0] {
        SCAN_NORM_FWD = 3'd0,
        SCAN_NORM_REV = 3'd1,
        SCAN_ILA_FWD  = 3'd2,
        SCAN_ILA_REV  = 3'd3,
        SCAN_ILB_FWD  = 3'd4,
        SCAN_ILB_REV  = 3'd5
    } scan_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SCAN  = 2'd2,
        ST_DONE  = 2'd3
    } seq_e;
endpackage

// File: rtl/lcd_scan_cfg.sv
module lcd_scan_cfg
    import lcd_scan_pkg::*;
(
    input  logic [SCAN_W-1:0]  raw_scan,
    input  logic [START_W-1:0] raw_start,
    input  logic [7:0]         raw_lines,
    input  logic [BLK_W-1:0]   raw_block,
    output scan_e              scan_o,
    output logic [COM_W-1:0]   first_pos,
    output logic [COM_W-1:0]   line_count,
    output logic [ADDR_W-1:0]  first_addr
);
    localparam logic [COM_W-1:0] COM_C = COM_W'(COM_N);

    logic [BLK_W-1:0]   blk_ok;
    logic [START_W-1:0] start_ok;
    logic [COM_W-1:0]   span;
    logic [COM_W-1:0]   lines_ext;

    always_comb begin
        // R6: an out-of-range block falls back to block 0
        blk_ok     = (int'(raw_block) < BLK_N) ? raw_block : '0;
        first_pos  = COM_W'(int'(blk_ok) * GRP);
        span       = COM_C - first_pos;
        lines_ext  = COM_W'(raw_lines);
        line_count = (lines_ext > span) ? span : lines_ext;
        // R7: an illegal start line falls back to 0
        start_ok   = (int'(raw_start) < START_N) ? raw_start : '0;
        first_addr = ADDR_W'(int'(start_ok) * GRP);
        // R5: unused codes select the plain ascending order
        scan_o     = (raw_scan <= 3'd5) ? scan_e'(raw_scan) : SCAN_NORM_FWD;
    end
endmodule

// File: rtl/lcd_scan_map.sv
module lcd_scan_map
    import lcd_scan_pkg::*;
(
    input  scan_e            scan,
    input  logic [COM_W-1:0] pos,
    output logic [COM_W-1:0] com
);
    localparam logic [COM_W-1:0] GRP_C  = COM_W'(GRP);
    localparam logic [COM_W-1:0] HALF_C = COM_W'(HALF);
    localparam logic [COM_W-1:0] LAST_C = COM_W'(COM_N - 1);

    logic [COM_W-1:0] grp;
    logic [COM_W-1:0] lane;
    logic [COM_W-1:0] pair;
    logic [COM_W-1:0] in_lo;
    logic [COM_W-1:0] ila;
    logic [COM_W-1:0] ilb;

    always_comb begin
        grp   = pos / GRP_C;
        lane  = pos % GRP_C;
        pair  = grp >> 1;
        in_lo = pair * GRP_C + lane;
        ila   = grp[0] ? (HALF_C + in_lo) : in_lo;
        ilb   = grp[0] ? in_lo : (HALF_C + in_lo);
        unique case (scan)
            SCAN_NORM_FWD: com = pos;
            SCAN_NORM_REV: com = LAST_C - pos;
            SCAN_ILA_FWD:  com = ila;
            SCAN_ILA_REV:  com = LAST_C - ila;
            SCAN_ILB_FWD:  com = ilb;
            SCAN_ILB_REV:  com = LAST_C - ilb;
            default:       com = pos;
        endcase
    end
endmodule

// File: rtl/lcd_com_sequencer.sv
module lcd_com_sequencer
    import lcd_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_tick,
    input  logic               frame_start,
    input  logic [SCAN_W-1:0]  cfg_scan,
    input  logic [START_W-1:0] cfg_start,
    input  logic [7:0]         cfg_lines,
    input  logic [BLK_W-1:0]   cfg_block,
    output logic [COM_W-1:0]   com_idx,
    output logic               com_valid,
    output logic [ADDR_W-1:0]  line_addr,
    output logic               frame_done
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(LINE_N - 1);

    seq_e              state_q, state_d;
    scan_e             scan_q;
    scan_e             ld_scan;
    logic [COM_W-1:0]  pos_q, left_q, map_com;
    logic [COM_W-1:0]  ld_pos, ld_cnt;
    logic [ADDR_W-1:0] addr_q, ld_addr;
    logic [COM_W-1:0]  com_q;
    logic [ADDR_W-1:0] line_q;
    logic              valid_q, done_q;
    logic              tick_live;

    lcd_scan_cfg u_cfg (
        .raw_scan   (cfg_scan),
        .raw_start  (cfg_start),
        .raw_lines  (cfg_lines),
        .raw_block  (cfg_block),
        .scan_o     (ld_scan),
        .first_pos  (ld_pos),
        .line_count (ld_cnt),
        .first_addr (ld_addr)
    );

    lcd_scan_map u_map (
        .scan (scan_q),
        .pos  (pos_q),
        .com  (map_com)
    );

    assign tick_live = line_tick && !frame_start &&
                       (state_q == ST_ARMED || state_q == ST_SCAN);

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED,
                ST_SCAN:  if (line_tick) state_d = (left_q == '0) ? ST_DONE : ST_SCAN;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scan_q  <= SCAN_NORM_FWD;
            pos_q   <= '0;
            left_q  <= '0;
            addr_q  <= '0;
            com_q   <= '0;
            line_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (frame_start) begin
                scan_q  <= ld_scan;
                pos_q   <= ld_pos;
                left_q  <= ld_cnt;
                addr_q  <= ld_addr;
                valid_q <= 1'b0;
            end else if (tick_live) begin
                if (left_q == '0) begin
                    valid_q <= 1'b0;
                    done_q  <= 1'b1;
                end else begin
                    com_q   <= map_com;
                    line_q  <= addr_q;
                    valid_q <= 1'b1;
                    pos_q   <= pos_q + 1'b1;
                    left_q  <= left_q - 1'b1;
                    addr_q  <= (addr_q == ADDR_LAST) ? '0 : addr_q + 1'b1;
                end
            end
        end
    end

    assign com_idx    = com_q;
    assign com_valid  = valid_q;
    assign line_addr  = line_q;
    assign frame_done = done_q;

    assert_com_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        com_valid |-> (int'(com_idx) < COM_N));

    assert_norm_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (com_valid && $past(com_valid) && $past(line_tick) && scan_q == SCAN_NORM_FWD)
        |-> (com_idx == $past(com_idx) + 1'b1));

    assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (com_valid && $past(com_valid) && $past(line_tick))
        |-> (line_addr == (($past(line_addr) == ADDR_LAST) ? '0 : ADDR_W'($past(line_addr) + 1'b1))));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_done_novalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !com_valid);

    assert_quiet_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_tick && !frame_start)
        |=> ($stable(com_idx) && $stable(line_addr) && $stable(com_valid)));

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !com_valid);
endmodule

// File: tb/test_lcd_com_sequencer.sv
`timescale 1ns/1ps
module test_lcd_com_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic       frame_start = 1'b0;
    logic [2:0] cfg_scan = '0;
    logic [6:0] cfg_start = '0;
    logic [7:0] cfg_lines = '0;
    logic [5:0] cfg_block = '0;
    logic [7:0] com_idx;
    logic       com_valid;
    logic [8:0] line_addr;
    logic       frame_done;

    int n_cmp = 0;
    int n_bad = 0;
    int e_scan, e_pos0, e_cnt, e_addr0, e_i;
    int last_com = 0;

    always #2.5 clk = ~clk;

    lcd_com_sequencer i_lcd_com_sequencer (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .frame_start(frame_start),
        .cfg_scan(cfg_scan), .cfg_start(cfg_start), .cfg_lines(cfg_lines),
        .cfg_block(cfg_block), .com_idx(com_idx), .com_valid(com_valid),
        .line_addr(line_addr), .frame_done(frame_done)
    );

    function automatic int half_walk(int p, int first_base, int second_base);
        int h = p / 8;
        int w = p % 8;
        if (w < 4) return first_base + 4 * h + w;
        return second_base + 4 * h + (w - 4);
    endfunction

    function automatic int exp_com(int sc, int p);
        case (sc)
            1:       return 183 - p;
            2:       return half_walk(p, 0, 92);
            3:       return 183 - half_walk(p, 0, 92);
            4:       return half_walk(p, 92, 0);
            5:       return 183 - half_walk(p, 92, 0);
            default: return p;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic launch(int sc, int st, int lines, int blk, bit with_tick);
        int b;
        @(negedge clk);
        cfg_scan = 3'(sc); cfg_start = 7'(st); cfg_lines = 8'(lines); cfg_block = 6'(blk);
        frame_start = 1'b1;
        line_tick = with_tick;
        e_scan  = (sc > 5) ? 0 : sc;
        b       = (blk > 45) ? 0 : blk;
        e_pos0  = 4 * b;
        e_cnt   = (lines > 184 - e_pos0) ? 184 - e_pos0 : lines;
        e_addr0 = (st > 91) ? 0 : 4 * st;
        e_i     = 0;
        @(negedge clk);
        frame_start = 1'b0;
        line_tick = 1'b0;
        // R10: scramble the configuration after capture
        cfg_scan = 3'($urandom); cfg_start = 7'($urandom);
        cfg_lines = 8'($urandom); cfg_block = 6'($urandom);
        chk("R10 valid after start", int'(com_valid), 0);
    endtask

    task automatic emit(int n, string req);
        for (int k = 0; k < n; k++) begin
            line_tick = 1'b1;
            @(negedge clk);
            line_tick = 1'b0;
            chk(req, int'(com_idx), exp_com(e_scan, e_pos0 + e_i));
            chk("R7 line address", int'(line_addr), (e_addr0 + e_i) % 368);
            chk("R6 valid inside window", int'(com_valid), 1);
            last_com = int'(com_idx);
            e_i++;
            @(negedge clk);
        end
    endtask

    task automatic finish_frame();
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        chk("R8 done pulse", int'(frame_done), 1);
        chk("R8 valid low at done", int'(com_valid), 0);
        @(negedge clk);
        chk("R8 done one cycle", int'(frame_done), 0);
    endtask

    task automatic frame(int sc, int st, int lines, int blk, string req);
        launch(sc, st, lines, blk, 1'b0);
        emit(e_cnt, req);
        finish_frame();
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0d_5ca7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 com_idx reset", int'(com_idx), 0);
        chk("R1 line_addr reset", int'(line_addr), 0);
        chk("R1 valid reset", int'(com_valid), 0);
        chk("R1 done reset", int'(frame_done), 0);
        repeat (2) begin
            line_tick = 1'b1; @(negedge clk); line_tick = 1'b0; @(negedge clk);
        end
        chk("R1 idle ticks valid", int'(com_valid), 0);
        chk("R1 idle ticks done", int'(frame_done), 0);
        chk("R1 idle ticks idx", int'(com_idx), 0);

        frame(0, 0, 184, 0, "R2 ascending");
        frame(1, 0, 184, 0, "R2 descending");
        frame(2, 0, 184, 0, "R3 lower-first");
        frame(3, 0, 184, 0, "R3 lower-first reversed");
        frame(4, 0, 184, 0, "R4 upper-first");
        frame(5, 0, 184, 0, "R4 upper-first reversed");
        frame(6, 0, 20, 0, "R5 code 6");
        frame(7, 3, 8, 3, "R5 code 7");
        frame(0, 0, 88, 1, "R6 window 88 at block 1");
        chk("R6 last of window", last_com, 91);
        frame(2, 5, 30, 10, "R6 window on interlace");
        frame(0, 0, 200, 40, "R6 clamped count");
        frame(0, 0, 10, 50, "R6 illegal block");
        frame(0, 90, 184, 0, "R7 address wrap");
        frame(1, 95, 10, 0, "R7 illegal start");
        frame(0, 0, 0, 0, "R8 zero lines");

        // R9: ticks after done are ignored
        frame(4, 2, 12, 0, "R9 short frame");
        repeat (3) begin
            line_tick = 1'b1; @(negedge clk); line_tick = 1'b0;
            chk("R9 done-state valid", int'(com_valid), 0);
            chk("R9 done-state done", int'(frame_done), 0);
            chk("R9 done-state idx", int'(com_idx), last_com);
            @(negedge clk);
        end

        // R10: restart mid-frame with a simultaneous tick
        launch(0, 0, 184, 0, 1'b0);
        emit(5, "R2 before restart");
        launch(4, 10, 40, 2, 1'b1);
        emit(e_cnt, "R10 restarted frame");
        finish_frame();

        for (int f = 0; f < 25; f++) begin
            frame(int'($urandom % 8), int'($urandom % 128), int'($urandom % 256),
                  int'($urandom % 64), "R6 random frame");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule